// File: doc/BRIEF.md
# Load/Store Alignment Unit

This unit is the memory-access stage of a small 32-bit processor core. For each request it takes an access kind, two register operands (base and index), the current program counter with an 8-bit literal word count, the store value and a 3-bit destination register number. It forms the effective address in the same cycle. It checks that address against the access size. It then drives a single-cycle synchronous data-memory port with per-byte lane enables.

Stores place the source value on the byte lanes that the address selects. Loads return one cycle later. The unit picks the addressed byte, halfword or word out of the returned word, zero- or sign-extends it to 32 bits and presents it with a valid strobe and the destination register number. A request whose address is not a multiple of its size raises an alignment fault, and no memory access is made.

Control is a two-state machine. `S_IDLE` means no load result is due. `S_RESP` means a load result is on the output this cycle. An accepted load moves `S_IDLE` to `S_RESP` (transition ISSUE), or keeps the machine in `S_RESP` (transition CHAIN). Any other cycle moves `S_RESP` back to `S_IDLE` (transition DONE), or leaves `S_IDLE` where it is (transition REST).

Top module: `lsu_align`

## Requirements
- R1: For every known kind other than the literal load, `mem_addr` equals `opnd_base + opnd_index` (modulo 2^32) in the cycle of the request.
- R2: Kind code 8 (literal load) is a word load from `(pc_now with bits 1:0 cleared) + 4*lit_words`, an offset of 0 to 1020 bytes. It never faults, and the operands are ignored.
- R3: A halfword access with address bit 0 set, or a word access with address bits 1:0 nonzero, raises `align_fault` in the same cycle with `mem_req` and `mem_we` low. A faulting store leaves memory unchanged, and a faulting load produces no result.
- R4: An accepted store raises `mem_req` and `mem_we`. Its byte enables are `1 << addr[1:0]` for a byte, `4'b0011` or `4'b1100` for a halfword (chosen by addr[1]) and `4'b1111` for a word. Lane 0 is bits 7:0 (little-endian).
- R5: Store data is replicated: a byte store drives the low byte on all four lanes, a halfword store drives the low halfword on both halves, and a word store drives the value unchanged.
- R6: Kind codes 1 and 2 return the addressed byte (lane addr[1:0]) or halfword (half addr[1]) zero-extended to 32 bits.
- R7: Kind codes 3 and 4 return the addressed byte or halfword sign-extended to 32 bits.
- R8: `ld_valid` is high exactly in the cycle after an accepted load (codes 0 to 4 and 8) and at no other time. Back-to-back loads give back-to-back results, and code 0 returns the whole word.
- R9: `ld_rt` carries the 3-bit register number given with the load request, aligned with `ld_valid`.
- R10: Kind codes are 0 word load, 1 unsigned byte load, 2 unsigned halfword load, 3 signed byte load, 4 signed halfword load, 5 word store, 6 byte store, 7 halfword store, 8 literal load. Codes 9 to 15, or `req_valid` low, cause no memory access, no fault and no result.
- R11: While `rst_n` is low and in the first cycle after, `mem_req` and `ld_valid` are low when no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 4 | Access kind code (R10) |
| req_rt | input | 3 | Destination register number for loads |
| opnd_base | input | 32 | Base register value |
| opnd_index | input | 32 | Index register value |
| pc_now | input | 32 | Current program counter |
| lit_words | input | 8 | Literal offset in words |
| store_val | input | 32 | Source register value for stores |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Byte lane enables |
| mem_addr | output | 32 | Effective byte address |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Read word, valid the cycle after a read |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| ld_rt | output | 3 | Register number of the result |
| align_fault | output | 1 | Misaligned access flagged |

## Verification
Suppose the state register or the captured kind, offset or register number is wrong. The bench then sees it at the next falling edge after a load request: a missing or extra `ld_valid`, a result extended the wrong way, a wrong lane, or a wrong `ld_rt`, all exactly one cycle after the request. Errors in address forming, lane enables, data replication or the fault decision appear at the memory port in the same cycle as the request. Store errors also show up later, when a readback load returns a word that differs from the bench's shadow memory.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;

    localparam logic [3:0] K_LDW   = 4'd0;
    localparam logic [3:0] K_LDUB  = 4'd1;
    localparam logic [3:0] K_LDUH  = 4'd2;
    localparam logic [3:0] K_LDSB  = 4'd3;
    localparam logic [3:0] K_LDSH  = 4'd4;
    localparam logic [3:0] K_STW   = 4'd5;
    localparam logic [3:0] K_STB   = 4'd6;
    localparam logic [3:0] K_STH   = 4'd7;
    localparam logic [3:0] K_LDLIT = 4'd8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    function automatic logic kind_is_load(input logic [3:0] k);
        return (k <= K_LDSH) || (k == K_LDLIT);
    endfunction

    function automatic logic kind_is_store(input logic [3:0] k);
        return (k >= K_STW) && (k <= K_STH);
    endfunction

    function automatic logic kind_known(input logic [3:0] k);
        return k <= K_LDLIT;
    endfunction

    function automatic acc_size_e kind_size(input logic [3:0] k);
        acc_size_e s;
        unique case (k)
            K_LDUB, K_LDSB, K_STB: s = SZ_BYTE;
            K_LDUH, K_LDSH, K_STH: s = SZ_HALF;
            default:               s = SZ_WORD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lsu_agen.sv
`timescale 1ns/1ps
module lsu_agen import lsu_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 8
) (
    input  logic [3:0]        kind,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  words,
    output logic [ADDR_W-1:0] addr,
    output acc_size_e         size,
    output logic              misaligned
);
    localparam int PAD_W = ADDR_W - OFF_W - 2;

    logic [ADDR_W-1:0] pc_word;
    logic [ADDR_W-1:0] lit_bytes;

    always_comb begin
        pc_word   = pc & ~ADDR_W'(3);
        lit_bytes = {{PAD_W{1'b0}}, words, 2'b00};
        size      = kind_size(kind);
        if (kind == K_LDLIT) begin
            addr = pc_word + lit_bytes;
        end else begin
            addr = base + index;
        end
        unique case (size)
            SZ_HALF: misaligned = addr[0];
            SZ_WORD: misaligned = |addr[1:0];
            default: misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_store_steer.sv
`timescale 1ns/1ps
module lsu_store_steer import lsu_pkg::*; #(
    parameter int DATA_W = 32
) (
    input  acc_size_e          size,
    input  logic [1:0]         addr_lo,
    input  logic [DATA_W-1:0]  data,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]  wdata
);
    localparam int LANES = DATA_W / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [1:0] LANE_ID = 2'(i);
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    be[i]          = (addr_lo == LANE_ID);
                    wdata[8*i +: 8] = data[7:0];
                end
                SZ_HALF: begin
                    be[i]          = (addr_lo[1] == LANE_ID[1]);
                    wdata[8*i +: 8] = data[8*(i%2) +: 8];
                end
                default: begin
                    be[i]          = 1'b1;
                    wdata[8*i +: 8] = data[8*i +: 8];
                end
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
`timescale 1ns/1ps
module lsu_load_extract import lsu_pkg::*; #(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        kind,
    input  logic [1:0]        off,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] shifted;
    logic [7:0]        byte_v;
    logic [15:0]       half_v;

    always_comb begin
        shifted = rdata >> {off, 3'b000};
        byte_v  = shifted[7:0];
        half_v  = off[1] ? rdata[31:16] : rdata[15:0];
        unique case (kind)
            K_LDUB:  result = {{(DATA_W-8){1'b0}}, byte_v};
            K_LDSB:  result = {{(DATA_W-8){byte_v[7]}}, byte_v};
            K_LDUH:  result = {{(DATA_W-16){1'b0}}, half_v};
            K_LDSH:  result = {{(DATA_W-16){half_v[15]}}, half_v};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_align.sv
`timescale 1ns/1ps
module lsu_align import lsu_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_kind,
    input  logic [IDX_W-1:0]  req_rt,
    input  logic [ADDR_W-1:0] opnd_base,
    input  logic [ADDR_W-1:0] opnd_index,
    input  logic [ADDR_W-1:0] pc_now,
    input  logic [OFF_W-1:0]  lit_words,
    input  logic [31:0]       store_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              ld_valid,
    output logic [31:0]       ld_data,
    output logic [IDX_W-1:0]  ld_rt,
    output logic              align_fault
);
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic {S_IDLE, S_RESP} fsm_e;

    fsm_e              state_q, state_d;
    logic [ADDR_W-1:0] ea;
    acc_size_e         size;
    logic              mis;
    logic [LANES-1:0]  steer_be;
    logic [DATA_W-1:0] steer_data;
    logic              known, accept, accept_load;
    logic [3:0]        pend_kind_q;
    logic [1:0]        pend_off_q;
    logic [IDX_W-1:0]  pend_rt_q;

    lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
        .kind(req_kind), .base(opnd_base), .index(opnd_index),
        .pc(pc_now), .words(lit_words),
        .addr(ea), .size(size), .misaligned(mis)
    );

    lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
        .size(size), .addr_lo(ea[1:0]), .data(store_val),
        .be(steer_be), .wdata(steer_data)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
        .kind(pend_kind_q), .off(pend_off_q), .rdata(mem_rdata),
        .result(ld_data)
    );

    always_comb begin
        known       = kind_known(req_kind);
        accept      = req_valid && known && !mis;
        accept_load = accept && kind_is_load(req_kind);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Request capture for the result cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_kind_q <= K_LDW;
            pend_off_q  <= 2'b00;
            pend_rt_q   <= '0;
        end else if (accept_load) begin
            pend_kind_q <= req_kind;
            pend_off_q  <= ea[1:0];
            pend_rt_q   <= req_rt;
        end
    end

    // Next state: ISSUE, CHAIN, DONE, REST
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = accept_load ? S_RESP : S_IDLE;
            S_RESP:  state_d = accept_load ? S_RESP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req     = accept;
        mem_we      = accept && kind_is_store(req_kind);
        mem_be      = accept ? steer_be : '0;
        mem_addr    = ea;
        mem_wdata   = steer_data;
        align_fault = req_valid && known && mis;
        ld_valid    = (state_q == S_RESP);
        ld_rt       = pend_rt_q;
    end

    AST_LIT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == K_LDLIT) |-> (mem_req && !mem_we && mem_addr[1:0] == 2'b00)) else $error("literal"); // R2
    AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!mem_req && !mem_we)) else $error("fault"); // R3
    AST_STORE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 || mem_be == 4'b1100 || mem_be == 4'b1111)) else $error("lanes"); // R4
    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> ld_valid) else $error("result late"); // R8
    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_req && !mem_we)) else $error("stray result"); // R8
    AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_kind > K_LDLIT) |-> (!mem_req && !align_fault)) else $error("unknown"); // R10
endmodule

// File: tb/lsu_align_tb_top.sv
`timescale 1ns/1ps
module lsu_align_tb_top;
    localparam time TCLK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = 4'd0;
    logic [2:0]  req_rt = 3'd0;
    logic [31:0] opnd_base = '0, opnd_index = '0, pc_now = '0, store_val = '0;
    logic [7:0]  lit_words = '0;
    logic        mem_req, mem_we, ld_valid, align_fault;
    logic [3:0]  mem_be;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [31:0] mem_rdata = '0;
    logic [2:0]  ld_rt;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] mm [0:63];
    logic [31:0] em [0:63];

    logic        pend_v = 1'b0;
    logic [31:0] pend_data = '0;
    logic [2:0]  pend_rt = '0;
    string       pend_tag = "R8";

    always #(TCLK/2) clk = ~clk;

    lsu_align dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_rt(req_rt), .opnd_base(opnd_base), .opnd_index(opnd_index),
        .pc_now(pc_now), .lit_words(lit_words), .store_val(store_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
        .ld_data(ld_data), .ld_rt(ld_rt), .align_fault(align_fault)
    );

    // Byte-enabled synchronous memory model
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) mm[mem_addr[7:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
        end else if (mem_req) begin
            mem_rdata <= mm[mem_addr[7:2]];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [3:0] k, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] pc, input logic [7:0] off,
                        input logic [31:0] sd, input logic [2:0] rt);
        logic        is_ld, is_st, flt, acc;
        int          sz;
        logic [31:0] ad, w, wd, res;
        logic [3:0]  be;
        @(negedge clk);
        chk("R8 ld_valid", {31'b0, ld_valid}, {31'b0, pend_v});
        if (pend_v) begin
            chk(pend_tag, ld_data, pend_data);
            chk("R9 ld_rt", {29'b0, ld_rt}, {29'b0, pend_rt});
        end
        req_valid = v; req_kind = k; opnd_base = a; opnd_index = b;
        pc_now = pc; lit_words = off; store_val = sd; req_rt = rt;
        #1;
        is_ld = (k <= 4) || (k == 8);
        is_st = (k >= 5) && (k <= 7);
        sz = (k == 1 || k == 3 || k == 6) ? 1 : (k == 2 || k == 4 || k == 7) ? 2 : 4;
        ad = (k == 8) ? ((pc & 32'hFFFF_FFFC) + 32'(off) * 4) : a + b;
        flt = v && (is_ld || is_st) && ((ad % sz) != 0);
        acc = v && (is_ld || is_st) && !flt;
        chk("R3/R10 align_fault", {31'b0, align_fault}, {31'b0, flt});
        chk("R10 mem_req", {31'b0, mem_req}, {31'b0, acc});
        chk("R4 mem_we", {31'b0, mem_we}, {31'b0, acc && is_st});
        if (acc) chk(k == 8 ? "R2 mem_addr" : "R1 mem_addr", mem_addr, ad);
        pend_v = acc && is_ld;
        if (acc && is_st) begin
            be = (sz == 4) ? 4'hF : (sz == 2) ? (ad[1] ? 4'hC : 4'h3) : (4'h1 << ad[1:0]);
            wd = (sz == 4) ? sd : (sz == 2) ? {2{sd[15:0]}} : {4{sd[7:0]}};
            chk("R4 mem_be", {28'b0, mem_be}, {28'b0, be});
            chk("R5 mem_wdata", mem_wdata, wd);
            for (int l = 0; l < 4; l++)
                if (be[l]) em[ad[7:2]][8*l +: 8] = wd[8*l +: 8];
        end
        if (pend_v) begin
            w = em[ad[7:2]];
            case (k)
                4'd1: begin res = (w >> (8 * ad[1:0])) & 32'hFF; pend_tag = "R6 byte zext"; end
                4'd2: begin res = (w >> (16 * ad[1])) & 32'hFFFF; pend_tag = "R6 half zext"; end
                4'd3: begin res = (w >> (8 * ad[1:0])) & 32'hFF;
                            if (res[7]) res = res | 32'hFFFF_FF00; pend_tag = "R7 byte sext"; end
                4'd4: begin res = (w >> (16 * ad[1])) & 32'hFFFF;
                            if (res[15]) res = res | 32'hFFFF_0000; pend_tag = "R7 half sext"; end
                4'd8: begin res = w; pend_tag = "R2 literal data"; end
                default: begin res = w; pend_tag = "R8 word data"; end
            endcase
            pend_data = res;
            pend_rt = rt;
        end
    endtask

    task automatic idle();
        step(1'b0, 4'd0, 32'd0, 32'd0, 32'd0, 8'd0, 32'd0, 3'd0);
    endtask

    initial begin
        #(TCLK * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lf;
        for (int i = 0; i < 64; i++) begin
            mm[i] = 32'(i) * 32'h9E37_79B1;
            em[i] = 32'(i) * 32'h9E37_79B1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset mem_req", {31'b0, mem_req}, 32'd0);
        chk("R11 reset ld_valid", {31'b0, ld_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 post-reset ld_valid", {31'b0, ld_valid}, 32'd0);

        // word store via base+index, then every load kind at every offset
        step(1, 4'd5, 32'd8, 32'd8, 0, 0, 32'h8081_7F01, 0);
        step(1, 4'd5, 32'd20, 32'd0, 0, 0, 32'h7FFF_8000, 0);
        for (int o = 0; o < 4; o++) begin
            step(1, 4'd1, 32'd16, 32'(o), 0, 0, 0, 3'(o));
            step(1, 4'd3, 32'd16, 32'(o), 0, 0, 0, 3'(o + 1));
        end
        for (int o = 0; o < 4; o += 2) begin
            step(1, 4'd2, 32'd20, 32'(o), 0, 0, 0, 3'd5);
            step(1, 4'd4, 32'd20, 32'(o), 0, 0, 0, 3'd6);
            step(1, 4'd4, 32'd16, 32'(o), 0, 0, 0, 3'd7);
        end
        step(1, 4'd0, 32'd16, 32'd0, 0, 0, 0, 3'd2);
        // byte stores at all lanes, halfword stores at both halves
        for (int o = 0; o < 4; o++)
            step(1, 4'd6, 32'd24, 32'(o), 0, 0, 32'h1234_56F0 + 32'(o), 0);
        step(1, 4'd0, 32'd24, 32'd0, 0, 0, 0, 3'd1);
        step(1, 4'd7, 32'd28, 32'd0, 0, 0, 32'hAAAA_BEEF, 0);
        step(1, 4'd7, 32'd28, 32'd2, 0, 0, 32'h5555_C001, 0);
        step(1, 4'd0, 32'd28, 32'd0, 0, 0, 0, 3'd3);
        // misaligned accesses: faults, no access, memory untouched
        step(1, 4'd0, 32'd17, 32'd0, 0, 0, 0, 3'd1);
        step(1, 4'd2, 32'd19, 32'd0, 0, 0, 0, 3'd1);
        step(1, 4'd5, 32'd16, 32'd2, 0, 0, 32'hDEAD_DEAD, 0);
        step(1, 4'd7, 32'd21, 32'd0, 0, 0, 32'hDEAD_DEAD, 0);
        step(1, 4'd4, 32'd0, 32'd23, 0, 0, 0, 3'd1);
        step(1, 4'd0, 32'd16, 32'd0, 0, 0, 0, 3'd4);
        step(1, 4'd0, 32'd20, 32'd0, 0, 0, 0, 3'd4);
        // literal loads: pc low bits dropped, operands ignored, max offset
        step(1, 4'd8, 32'd1, 32'd2, 32'h0000_0013, 8'd0, 0, 3'd1);
        step(1, 4'd8, 32'd3, 32'd0, 32'h0000_0102, 8'd1, 0, 3'd2);
        step(1, 4'd8, 32'd5, 32'd6, 32'h0000_0101, 8'd255, 0, 3'd3);
        // unknown kinds and no-request cycles
        step(1, 4'd9, 32'd16, 32'd0, 0, 0, 32'hFFFF_FFFF, 0);
        step(1, 4'd15, 32'd17, 32'd0, 0, 0, 32'hFFFF_FFFF, 0);
        step(0, 4'd0, 32'd16, 32'd0, 0, 0, 0, 0);
        step(0, 4'd5, 32'd16, 32'd0, 0, 0, 32'hFFFF_FFFF, 0);
        step(1, 4'd0, 32'd16, 32'd0, 0, 0, 0, 3'd7);
        idle();
        // deterministic mixed traffic
        lf = 32'h1ACE;
        for (int n = 0; n < 400; n++) begin
            logic [3:0] kk;
            lf = (lf * 1103515245 + 12345) & 32'h7FFF_FFFF;
            kk = 4'((lf >> 4) % 11);
            step((lf & 32'h7) != 0, kk, 32'((lf >> 8) & 32'hFC), 32'((lf >> 16) & 32'h7),
                 32'((lf >> 3) & 32'hFF), 8'(lf >> 11), 32'(lf * 7), 3'(lf >> 20));
        end
        idle();
        idle();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule